// File: doc/BRIEF.md
# Floating-Point Result Sign Unit

This block owns the sign bit of a floating-point result while a controlling sequencer works on the magnitude. On the first cycle of an operation the sequencer raises a start strobe together with the three operand signs and the operation flags (subtract, negate-result, multiply-add). The block captures those flags and seeds a working sign. On later cycles the sequencer issues one small sign micro-operation per cycle. The set of micro-operations is fixed: hold, invert, exclusive-or with the captured subtract flag, and copy the sign of a chosen operand.

When the magnitude is done, the sequencer raises a finish strobe along with the result facts: whether the result is a NaN, the rounding mode, whether the result is an exact cancellation zero, and whether rounding was inexact. The block forms the final sign and registers it. That registered value is used on the following cycle both for the result-class field and for packing the result word. Because the final sign comes from a single register, the class field and the packed word always agree.

All pins are plain control and status signals. No data stream crosses the block's edge, so it has no valid/ready handshake and applies no back-pressure. The sequencer alone decides when each strobe is raised.

Top module: `fp_rsign_unit`

## Requirements
- R1: While reset is active and on the first cycle after it, `work_sign_o`, `final_sign_o` and `final_vld_o` are all 0.
- R2: A cycle with `start_i` high loads the working sign, visible on the next cycle. For a multiply-add (`madd_i`=1) the loaded value is `sign_b_i` XOR `sub_i`; otherwise it is `sign_a_i`. The cycle also captures the operand signs and the subtract and negate flags for later use.
- R3: Sign-op code 1 (invert) complements the working sign one cycle later.
- R4: Sign-op code 2 replaces the working sign with its XOR against the subtract flag captured at start.
- R5: Sign-op code 3 copies a captured operand sign into the working sign. The operand is chosen by `osel_i`: 0 selects A, 1 selects B, 2 selects C, and 3 clears the sign to positive (0).
- R6: Sign-op code 0 holds the working sign, and so do the reserved codes 4 to 7.
- R7: A finish cycle (`fin_i`=1) makes `final_vld_o` high for exactly the next cycle; `final_vld_o` is low after any cycle without finish. With no NaN and no exact-zero rule, the final sign is the working sign as it stood in the finish cycle, XOR the captured negate flag. `final_sign_o` holds its value between finishes.
- R8: If `zero_exact_i`=1 and `inexact_i`=0 at finish, and the result is not a NaN, the pre-negate sign is 1 when `rmode_i` is 3 (toward minus infinity). It is 0 for modes 0 (nearest), 1 (toward zero) and 2 (toward plus infinity). The captured negate flag is then applied.
- R9: When `inexact_i`=1, `zero_exact_i` has no effect: the final sign is the working sign XOR negate.
- R10: When `nan_i`=1 at finish, the final sign equals the working sign. Negate, rounding mode and the zero rule are all ignored.
- R11: In a cycle with `start_i` high, `sop_i` is ignored; the start load of R2 wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | First cycle of an operation |
| sign_a_i | input | 1 | Sign of operand A (sampled at start) |
| sign_b_i | input | 1 | Sign of operand B (sampled at start) |
| sign_c_i | input | 1 | Sign of operand C (sampled at start) |
| sub_i | input | 1 | Subtract flag (sampled at start) |
| neg_i | input | 1 | Negate-result flag (sampled at start) |
| madd_i | input | 1 | Multiply-add operation (sampled at start) |
| sop_i | input | 3 | Sign micro-operation code |
| osel_i | input | 2 | Operand select for the copy operation |
| fin_i | input | 1 | Finish strobe: form the final sign |
| nan_i | input | 1 | Result is a NaN (at finish) |
| rmode_i | input | 2 | Rounding mode (at finish) |
| zero_exact_i | input | 1 | Result is a cancellation zero (at finish) |
| inexact_i | input | 1 | Rounding was inexact (at finish) |
| work_sign_o | output | 1 | Registered working sign |
| final_sign_o | output | 1 | Registered final sign for class field and packing |
| final_vld_o | output | 1 | Final sign updated on this cycle |

## Verification
The bench aims at the exact-zero rule under every rounding mode. A design that ignored the inexact flag would give a truncated-to-zero result a minus sign under round-down. A design that applied the rule to NaNs, or negated NaNs, would flip a NaN's sign. The reserved sign-op codes and a start cycle carrying a non-hold code are driven on purpose; a decoder that treats the unused codes as live, or lets the sign op override the start load, corrupts the working sign. The multiply-add seed is checked with subtract set and clear, and the copy select is checked with all four values, including the clear-to-positive code.

// File: rtl/fp_rsign_pkg.sv
package fp_rsign_pkg;
  localparam int SOP_W = 3;
  localparam int SEL_W = 2;
  localparam int RM_W  = 2;

  typedef enum logic [SOP_W-1:0] {
    SOP_HOLD = 3'd0,
    SOP_INV  = 3'd1,
    SOP_XSUB = 3'd2,
    SOP_COPY = 3'd3
  } sop_e;

  localparam logic [SEL_W-1:0] OSEL_A   = 2'd0;
  localparam logic [SEL_W-1:0] OSEL_B   = 2'd1;
  localparam logic [SEL_W-1:0] OSEL_C   = 2'd2;
  localparam logic [SEL_W-1:0] OSEL_POS = 2'd3;

  localparam logic [RM_W-1:0] RM_DOWN = 2'd3;

  typedef struct packed {
    logic sa;
    logic sb;
    logic sc;
    logic sub;
    logic neg;
  } op_ctx_t;
endpackage

// File: rtl/rsign_ctx.sv
module rsign_ctx
  import fp_rsign_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    start_i,
  input  logic    sign_a_i,
  input  logic    sign_b_i,
  input  logic    sign_c_i,
  input  logic    sub_i,
  input  logic    neg_i,
  input  logic    madd_i,
  output op_ctx_t ctx_o,
  output logic    seed_o
);
  op_ctx_t ctx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctx_q <= '0;
    end else if (start_i) begin
      ctx_q.sa  <= sign_a_i;
      ctx_q.sb  <= sign_b_i;
      ctx_q.sc  <= sign_c_i;
      ctx_q.sub <= sub_i;
      ctx_q.neg <= neg_i;
    end
  end

  // multiply-add begins from B with subtraction folded in
  always_comb begin
    if (madd_i) seed_o = sign_b_i ^ sub_i;
    else        seed_o = sign_a_i;
  end

  assign ctx_o = ctx_q;
endmodule

// File: rtl/rsign_alu.sv
module rsign_alu
  import fp_rsign_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             seed_i,
  input  logic [SOP_W-1:0] sop_i,
  input  logic [SEL_W-1:0] osel_i,
  input  op_ctx_t          ctx_i,
  output logic             work_o
);
  logic work_q;
  logic work_d;
  logic pick;

  always_comb begin
    unique case (osel_i)
      OSEL_A:  pick = ctx_i.sa;
      OSEL_B:  pick = ctx_i.sb;
      OSEL_C:  pick = ctx_i.sc;
      default: pick = 1'b0;
    endcase
  end

  always_comb begin
    work_d = work_q;
    if (start_i) begin
      work_d = seed_i;
    end else begin
      case (sop_i)
        SOP_INV:  work_d = ~work_q;
        SOP_XSUB: work_d = work_q ^ ctx_i.sub;
        SOP_COPY: work_d = pick;
        default:  work_d = work_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) work_q <= 1'b0;
    else        work_q <= work_d;
  end

  assign work_o = work_q;
endmodule

// File: rtl/rsign_final.sv
module rsign_final
  import fp_rsign_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fin_i,
  input  logic            work_i,
  input  logic            neg_i,
  input  logic            nan_i,
  input  logic [RM_W-1:0] rmode_i,
  input  logic            zero_exact_i,
  input  logic            inexact_i,
  output logic            sign_o,
  output logic            vld_o
);
  logic base;
  logic fsign;
  logic sign_q;
  logic vld_q;

  // the zero rule needs a truly exact zero, not one produced by rounding
  always_comb begin
    if (zero_exact_i && !inexact_i) base = (rmode_i == RM_DOWN);
    else                            base = work_i;
    fsign = nan_i ? work_i : (base ^ neg_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sign_q <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= fin_i;
      if (fin_i) sign_q <= fsign;
    end
  end

  assign sign_o = sign_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/fp_rsign_unit.sv
module fp_rsign_unit
  import fp_rsign_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       sign_a_i,
  input  logic       sign_b_i,
  input  logic       sign_c_i,
  input  logic       sub_i,
  input  logic       neg_i,
  input  logic       madd_i,
  input  logic [2:0] sop_i,
  input  logic [1:0] osel_i,
  input  logic       fin_i,
  input  logic       nan_i,
  input  logic [1:0] rmode_i,
  input  logic       zero_exact_i,
  input  logic       inexact_i,
  output logic       work_sign_o,
  output logic       final_sign_o,
  output logic       final_vld_o
);
  op_ctx_t ctx;
  logic    seed;
  logic    work;

  rsign_ctx u_ctx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start_i),
    .sign_a_i (sign_a_i),
    .sign_b_i (sign_b_i),
    .sign_c_i (sign_c_i),
    .sub_i    (sub_i),
    .neg_i    (neg_i),
    .madd_i   (madd_i),
    .ctx_o    (ctx),
    .seed_o   (seed)
  );

  rsign_alu u_alu (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .seed_i  (seed),
    .sop_i   (sop_i),
    .osel_i  (osel_i),
    .ctx_i   (ctx),
    .work_o  (work)
  );

  rsign_final u_fin (
    .clk          (clk),
    .rst_n        (rst_n),
    .fin_i        (fin_i),
    .work_i       (work),
    .neg_i        (ctx.neg),
    .nan_i        (nan_i),
    .rmode_i      (rmode_i),
    .zero_exact_i (zero_exact_i),
    .inexact_i    (inexact_i),
    .sign_o       (final_sign_o),
    .vld_o        (final_vld_o)
  );

  assign work_sign_o = work;
endmodule

// File: rtl/fp_rsign_unit_chk.sv
module fp_rsign_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       sign_a_i,
  input logic       sign_b_i,
  input logic       sub_i,
  input logic       madd_i,
  input logic [2:0] sop_i,
  input logic       fin_i,
  input logic       nan_i,
  input logic       work_sign_o,
  input logic       final_sign_o,
  input logic       final_vld_o
);
  AST_START_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> work_sign_o == ($past(madd_i) ? ($past(sign_b_i) ^ $past(sub_i)) : $past(sign_a_i))); // R2
  AST_INVERT: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && sop_i == 3'd1) |=> work_sign_o != $past(work_sign_o)); // R3
  AST_HOLD_CODES: assert property (@(posedge clk) disable iff (!rst_n)
    (!start_i && (sop_i == 3'd0 || sop_i[2])) |=> $stable(work_sign_o)); // R6
  AST_VLD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> final_vld_o); // R7
  AST_VLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> !final_vld_o); // R7
  AST_FINAL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !fin_i |=> $stable(final_sign_o)); // R7
  AST_NAN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_i && nan_i) |=> final_sign_o == $past(work_sign_o)); // R10
endmodule

bind fp_rsign_unit fp_rsign_unit_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .sign_a_i     (sign_a_i),
  .sign_b_i     (sign_b_i),
  .sub_i        (sub_i),
  .madd_i       (madd_i),
  .sop_i        (sop_i),
  .fin_i        (fin_i),
  .nan_i        (nan_i),
  .work_sign_o  (work_sign_o),
  .final_sign_o (final_sign_o),
  .final_vld_o  (final_vld_o)
);

// File: tb/fp_rsign_unit_tb.sv
`timescale 1ns/1ps
module fp_rsign_unit_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 0, sign_a_i = 0, sign_b_i = 0, sign_c_i = 0;
  logic sub_i = 0, neg_i = 0, madd_i = 0;
  logic [2:0] sop_i = 0;
  logic [1:0] osel_i = 0;
  logic fin_i = 0, nan_i = 0, zero_exact_i = 0, inexact_i = 0;
  logic [1:0] rmode_i = 0;
  logic work_sign_o, final_sign_o, final_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  // model state
  bit m_work = 0, m_a = 0, m_b = 0, m_c = 0, m_sub = 0, m_neg = 0, m_final = 0;

  always #2.5 clk = ~clk;

  fp_rsign_unit u_dut (.*);

  function automatic bit fsign(bit w, bit ng, bit nan, bit zx, bit inx, bit [1:0] rm);
    bit b;
    if (nan) return w;
    b = (zx && !inx) ? (rm == 2'd3) : w;
    return b ^ ng;
  endfunction

  task automatic chk(bit act, bit exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(bit st, bit a, bit b, bit c, bit sb, bit ng, bit md,
                       bit [2:0] op, bit [1:0] sel,
                       bit fn, bit nan, bit [1:0] rm, bit zx, bit inx, string req);
    bit pick;
    start_i = st; sign_a_i = a; sign_b_i = b; sign_c_i = c;
    sub_i = sb; neg_i = ng; madd_i = md; sop_i = op; osel_i = sel;
    fin_i = fn; nan_i = nan; rmode_i = rm; zero_exact_i = zx; inexact_i = inx;
    if (fn) m_final = fsign(m_work, m_neg, nan, zx, inx, rm);
    if (st) begin
      m_a = a; m_b = b; m_c = c; m_sub = sb; m_neg = ng;
      m_work = md ? (b ^ sb) : a;
    end else begin
      case (sel)
        2'd0: pick = m_a;
        2'd1: pick = m_b;
        2'd2: pick = m_c;
        default: pick = 1'b0;
      endcase
      case (op)
        3'd1: m_work = ~m_work;
        3'd2: m_work = m_work ^ m_sub;
        3'd3: m_work = pick;
        default: ;
      endcase
    end
    @(posedge clk); #1;
    chk(work_sign_o, m_work, req);
    chk(final_vld_o, fn, "R7 valid");
    if (fn) chk(final_sign_o, m_final, req);
  endtask

  task automatic idle_op(bit [2:0] op, bit [1:0] sel, string req);
    apply(0, 0, 0, 0, 0, 0, 0, op, sel, 0, 0, 0, 0, 0, req);
  endtask

  task automatic finish(bit nan, bit [1:0] rm, bit zx, bit inx, string req);
    apply(0, 0, 0, 0, 0, 0, 0, 3'd0, 2'd0, 1, nan, rm, zx, inx, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1;
    chk(work_sign_o, 0, "R1 work"); chk(final_sign_o, 0, "R1 final"); chk(final_vld_o, 0, "R1 vld");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(work_sign_o, 0, "R1 post"); chk(final_vld_o, 0, "R1 post vld");

    // R2: seeds
    apply(1, 1, 0, 0, 0, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, "R2 add seed A");
    apply(1, 0, 1, 0, 1, 0, 1, 3'd0, 0, 0, 0, 0, 0, 0, "R2 madd sub");
    apply(1, 1, 1, 0, 0, 0, 1, 3'd0, 0, 0, 0, 0, 0, 0, "R2 madd nosub");
    // R11: start with live op code
    apply(1, 0, 1, 1, 0, 0, 0, 3'd1, 0, 0, 0, 0, 0, 0, "R11 start wins");
    // R3, R4
    idle_op(3'd1, 0, "R3 invert");
    apply(1, 1, 0, 1, 1, 1, 0, 3'd0, 0, 0, 0, 0, 0, 0, "R2 seed");
    idle_op(3'd2, 0, "R4 xor sub");
    // R5 all selects
    idle_op(3'd3, 2'd0, "R5 copy A");
    idle_op(3'd3, 2'd1, "R5 copy B");
    idle_op(3'd3, 2'd2, "R5 copy C");
    idle_op(3'd3, 2'd3, "R5 clear");
    idle_op(3'd1, 0, "R3 invert");
    // R6 reserved codes
    for (int k = 4; k < 8; k++) idle_op(k[2:0], 2'd3, "R6 reserved");
    idle_op(3'd0, 0, "R6 hold");
    // R7 plain finish with negate (captured neg=1)
    finish(0, 2'd0, 0, 0, "R7 final");
    idle_op(3'd0, 0, "R7 quiet");
    // R8 every rounding mode, neg = 0 and 1
    for (int ng = 0; ng < 2; ng++)
      for (int rm = 0; rm < 4; rm++) begin
        apply(1, 1, 1, 0, 1, ng[0], 0, 3'd0, 0, 0, 0, 0, 0, 0, "R2 seed");
        finish(0, rm[1:0], 1, 0, "R8 exact zero");
      end
    // R9 inexact blocks rule
    apply(1, 1, 0, 0, 1, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, "R2 seed");
    finish(0, 2'd3, 1, 1, "R9 inexact");
    apply(1, 0, 0, 0, 1, 0, 0, 3'd0, 0, 0, 0, 0, 0, 0, "R2 seed");
    finish(0, 2'd3, 1, 1, "R9 inexact down");
    // R10 NaN
    apply(1, 1, 0, 0, 0, 1, 0, 3'd0, 0, 0, 0, 0, 0, 0, "R2 seed");
    finish(1, 2'd3, 1, 0, "R10 nan");

    // random transactions
    for (int t = 0; t < 400; t++) begin
      int nops;
      apply(1, $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
            $urandom_range(0,7), $urandom_range(0,3), 0, 0, 0, 0, 0, "R2 rand seed");
      nops = $urandom_range(0, 5);
      for (int k = 0; k < nops; k++)
        idle_op($urandom_range(0,7), $urandom_range(0,3), "R5 rand op");
      finish($urandom_range(0,3) == 0, $urandom_range(0,3), $urandom_range(0,1),
             $urandom_range(0,1), "R8 rand final");
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule